// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration space of one type-0 PCI function. A host-side access engine presents a byte offset, an access size (byte, word or dword) and, for writes, a data word. Reads are combinational and return the addressed bytes little-endian and zero-extended. Writes pass lane by lane through rules chosen by offset. Identification bytes are fixed by parameters. Base address registers accept only full, aligned dword writes, and those writes are masked to the region size. The expansion ROM base keeps its enable bit. Reserved command bits hold their value. The status high byte clears a bit when a 1 is written to it.

Device logic reports error events on a set input, which raises bits in the status high byte. Two level outputs carry the I/O-decode and memory-decode enables from the command register. A one-cycle remap pulse follows every write that touches the command register, so that downstream address decoders can reload their windows.

Top module: `cfghdr_regfile`

## Requirements
- R1: Offsets 0x00-0x03 (vendor and device ID), 0x08 (revision), 0x09-0x0B (class code) and 0x0E (header type) read their parameter values, and writes to them have no effect.
- R2: The size input is encoded 0 = byte, 1 = word, 2 = dword. A read returns the byte at the given offset in rdata[7:0] and the following bytes in higher lanes (little-endian). Lanes beyond the access size read zero.
- R3: An aligned dword write to a base address register at 0x10-0x27 (six registers, four bytes each) stores the data with the low log2(size) bits cleared. The defaults are 4 KiB for the register at 0x10 and 32 bytes for the one at 0x14.
- R4: A base address register with size parameter 0 reads zero after any write.
- R5: Byte and word writes that fall in 0x10-0x27 or 0x30-0x33 are ignored. Writes of any size to 0x38-0x3B are ignored.
- R6: An aligned dword write to the ROM base at 0x30 keeps bit 0 as written and clears bits 1 to log2(ROM size)-1. The default ROM size is 64 KiB.
- R7: At offset 0x05, bits 3-7 (command bits 11-15) keep their value on writes, and bits 0-2 take the written value.
- R8: Offset 0x06 is read-only and reads its parameter value, which defaults to 0x00.
- R9: At offset 0x07, a bit in the W1C mask (default 0xF9) is set by the matching err_set bit and cleared by writing 1. Writing 0 leaves it unchanged. Bits outside the mask stay zero.
- R10: remap_pulse is high for the cycle after every write whose bytes include offset 0x04 or 0x05, and is low after any other cycle.
- R11: io_en follows command bit 0 and mem_en follows command bit 1, changing in the cycle after the write.
- R12: All other offsets are plain read/write storage, each byte lane independent.
- R13: Synchronous reset clears all stored bytes, io_en, mem_en and remap_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current offset and size |
| addr | input | 8 | Byte offset of the access |
| size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| wdata | input | 32 | Write data, lowest offset in bits 7:0 |
| err_set | input | 8 | Sets bits in the status high byte (masked) |
| rdata | output | 32 | Read data for addr/size, combinational |
| io_en | output | 1 | I/O-space decode enable (command bit 0) |
| mem_en | output | 1 | Memory-space decode enable (command bit 1) |
| remap_pulse | output | 1 | One-cycle pulse after a command register write |

## Verification
The assertions take it for granted that size never carries the unused code 3 and that reset is held for at least one clock edge. Any err_set pattern and any offset are acceptable to them. The stimulus uses only the three defined sizes and keeps dword accesses to windows aligned. Unaligned word reads are used only on plain storage. Reset is applied for several cycles, both at the start and in the middle of the run.

// File: rtl/cfghdr_pkg.sv
package cfghdr_pkg;

    localparam int OFF_W     = 8;
    localparam int NBYTES    = 1 << OFF_W;
    localparam int LANES     = 4;
    localparam int DATA_W    = LANES * 8;
    localparam int BAR_COUNT = 6;
    localparam int LOG2_W    = 6;

    localparam logic [7:0] CMD_LO_OFF   = 8'h04;
    localparam logic [7:0] CMD_HI_OFF   = 8'h05;
    localparam logic [7:0] STAT_HI_OFF  = 8'h07;
    localparam logic [7:0] BAR_FIRST    = 8'h10;
    localparam logic [7:0] BAR_END      = BAR_FIRST + 8'(BAR_COUNT * 4);
    localparam logic [7:0] ROM_OFF      = 8'h30;
    localparam logic [7:0] ROM_RSV_OFF  = 8'h38;
    localparam logic [7:0] CMD_HI_WMASK = 8'h07;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } acc_size_e;

    typedef enum logic [2:0] {
        BK_PLAIN,
        BK_FIXED,
        BK_CMD_HI,
        BK_STAT_LO,
        BK_STAT_HI,
        BK_WINDOW
    } byte_kind_e;

    typedef struct packed {
        logic       en;
        logic [7:0] off;
        logic [7:0] val;
    } lane_wr_t;

    function automatic byte_kind_e classify(input logic [7:0] off);
        byte_kind_e k;
        if (off <= 8'h03 || (off >= 8'h08 && off <= 8'h0B) || off == 8'h0E)
            k = BK_FIXED;
        else if (off == CMD_HI_OFF)
            k = BK_CMD_HI;
        else if (off == 8'h06)
            k = BK_STAT_LO;
        else if (off == STAT_HI_OFF)
            k = BK_STAT_HI;
        else if ((off >= BAR_FIRST && off < BAR_END) ||
                 (off >= ROM_OFF && off <= ROM_OFF + 8'd3) ||
                 (off >= ROM_RSV_OFF && off <= ROM_RSV_OFF + 8'd3))
            k = BK_WINDOW;
        else
            k = BK_PLAIN;
        return k;
    endfunction

    function automatic logic [2:0] lane_count(input logic [1:0] sz);
        logic [2:0] n;
        case (sz)
            SZ_BYTE: n = 3'd1;
            SZ_WORD: n = 3'd2;
            default: n = 3'd4;
        endcase
        return n;
    endfunction

    function automatic logic [DATA_W-1:0] region_mask(input logic [LOG2_W-1:0] lg);
        logic [DATA_W-1:0] m;
        if (lg == '0)
            m = '0;
        else
            m = ~((DATA_W'(1) << lg) - DATA_W'(1));
        return m;
    endfunction

endpackage

// File: rtl/cfghdr_bar_mask.sv
module cfghdr_bar_mask
    import cfghdr_pkg::*;
#(
    parameter logic [BAR_COUNT*LOG2_W-1:0] BAR_LOG2_PACK = '0,
    parameter logic [LOG2_W-1:0]           ROM_LOG2      = '0
) (
    output logic [BAR_COUNT-1:0][DATA_W-1:0] bar_mask,
    output logic [DATA_W-1:0]                rom_mask
);
    for (genvar b = 0; b < BAR_COUNT; b++) begin : g_bar
        localparam logic [LOG2_W-1:0] LG = BAR_LOG2_PACK[b*LOG2_W +: LOG2_W];
        assign bar_mask[b] = region_mask(LG);
    end

    // Bit 0 is the enable and is merged by the write filter.
    assign rom_mask = region_mask(ROM_LOG2) & ~DATA_W'(1);
endmodule

// File: rtl/cfghdr_write_filter.sv
module cfghdr_write_filter
    import cfghdr_pkg::*;
#(
    parameter logic [7:0] STAT_HI_W1C = 8'hF9
) (
    input  logic                             wr_en,
    input  logic [7:0]                       addr,
    input  logic [1:0]                       size,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [LANES-1:0][7:0]            old_b,
    input  logic [BAR_COUNT-1:0][DATA_W-1:0] bar_mask,
    input  logic [DATA_W-1:0]                rom_mask,
    output lane_wr_t [LANES-1:0]             lanes,
    output logic                             touch_cmd
);
    logic [2:0]        nl;
    logic              is_bar, is_rom, win_path;
    logic [7:0]        rel;
    logic [2:0]        bidx;
    logic [DATA_W-1:0] win_val;

    always_comb begin
        nl     = lane_count(size);
        rel    = addr - BAR_FIRST;
        bidx   = rel[4:2];
        is_bar = (addr >= BAR_FIRST) && (addr < BAR_END);
        is_rom = (addr == ROM_OFF);
        win_path = wr_en && (size == SZ_DWORD) && (addr[1:0] == 2'b00) && (is_bar || is_rom);
        if (is_rom)
            win_val = (wdata & rom_mask) | {{(DATA_W-1){1'b0}}, wdata[0]};
        else if (bidx < 3'(BAR_COUNT))
            win_val = wdata & bar_mask[bidx];
        else
            win_val = '0;
    end

    always_comb begin
        touch_cmd = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            logic       live;
            logic [7:0] off, wb;
            off  = addr + 8'(i);
            wb   = wdata[8*i +: 8];
            live = wr_en && (3'(i) < nl);
            lanes[i].off = off;
            lanes[i].en  = 1'b0;
            lanes[i].val = old_b[i];
            if (live && (off == CMD_LO_OFF || off == CMD_HI_OFF))
                touch_cmd = 1'b1;
            if (win_path) begin
                lanes[i].en  = 1'b1;
                lanes[i].val = win_val[8*i +: 8];
            end else if (live) begin
                case (classify(off))
                    BK_PLAIN: begin
                        lanes[i].en  = 1'b1;
                        lanes[i].val = wb;
                    end
                    BK_CMD_HI: begin
                        lanes[i].en  = 1'b1;
                        lanes[i].val = (old_b[i] & ~CMD_HI_WMASK) | (wb & CMD_HI_WMASK);
                    end
                    BK_STAT_HI: begin
                        lanes[i].en  = 1'b1;
                        lanes[i].val = old_b[i] & ~(wb & STAT_HI_W1C);
                    end
                    default: lanes[i].en = 1'b0;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfghdr_read_mux.sv
module cfghdr_read_mux
    import cfghdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h0,
    parameter logic [15:0] DEVICE_ID   = 16'h0,
    parameter logic [7:0]  REVISION    = 8'h0,
    parameter logic [23:0] CLASS_CODE  = 24'h0,
    parameter logic [7:0]  HEADER_TYPE = 8'h0,
    parameter logic [7:0]  STAT_LO_VAL = 8'h0
) (
    input  logic [7:0]             addr,
    input  logic [1:0]             size,
    input  logic [NBYTES-1:0][7:0] cfg,
    output logic [DATA_W-1:0]      rdata
);
    function automatic logic [7:0] fixed_byte(input logic [7:0] off);
        logic [7:0] v;
        case (off)
            8'h00:   v = VENDOR_ID[7:0];
            8'h01:   v = VENDOR_ID[15:8];
            8'h02:   v = DEVICE_ID[7:0];
            8'h03:   v = DEVICE_ID[15:8];
            8'h08:   v = REVISION;
            8'h09:   v = CLASS_CODE[7:0];
            8'h0A:   v = CLASS_CODE[15:8];
            8'h0B:   v = CLASS_CODE[23:16];
            8'h0E:   v = HEADER_TYPE;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    logic [2:0] nl;

    always_comb begin
        nl    = lane_count(size);
        rdata = '0;
        for (int i = 0; i < LANES; i++) begin
            logic [7:0] off;
            off = addr + 8'(i);
            if (3'(i) < nl) begin
                case (classify(off))
                    BK_FIXED:   rdata[8*i +: 8] = fixed_byte(off);
                    BK_STAT_LO: rdata[8*i +: 8] = STAT_LO_VAL;
                    default:    rdata[8*i +: 8] = cfg[off];
                endcase
            end
        end
    end
endmodule

// File: rtl/cfghdr_regfile.sv
module cfghdr_regfile
    import cfghdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'h1B36,
    parameter logic [15:0] DEVICE_ID   = 16'h00A5,
    parameter logic [7:0]  REVISION    = 8'h02,
    parameter logic [23:0] CLASS_CODE  = 24'h020000,
    parameter logic [7:0]  HEADER_TYPE = 8'h00,
    parameter logic [7:0]  STAT_LO_VAL = 8'h00,
    parameter logic [7:0]  STAT_HI_W1C = 8'hF9,
    parameter logic [BAR_COUNT*LOG2_W-1:0] BAR_LOG2_PACK =
        {6'd0, 6'd0, 6'd0, 6'd0, 6'd5, 6'd12},
    parameter logic [LOG2_W-1:0] ROM_LOG2 = 6'd16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        addr,
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] wdata,
    input  logic [7:0]        err_set,
    output logic [DATA_W-1:0] rdata,
    output logic              io_en,
    output logic              mem_en,
    output logic              remap_pulse
);
    logic [NBYTES-1:0][7:0]            cfg_q;
    logic [BAR_COUNT-1:0][DATA_W-1:0]  bar_mask;
    logic [DATA_W-1:0]                 rom_mask;
    logic [LANES-1:0][7:0]             old_b;
    lane_wr_t [LANES-1:0]              lanes;
    logic                              touch_cmd;
    logic                              remap_q;
    logic [7:0]                        stat_hi_after;
    logic [7:0]                        stat_set;

    cfghdr_bar_mask #(
        .BAR_LOG2_PACK(BAR_LOG2_PACK),
        .ROM_LOG2     (ROM_LOG2)
    ) u_mask (
        .bar_mask(bar_mask),
        .rom_mask(rom_mask)
    );

    always_comb begin
        for (int i = 0; i < LANES; i++)
            old_b[i] = cfg_q[addr + 8'(i)];
    end

    cfghdr_write_filter #(
        .STAT_HI_W1C(STAT_HI_W1C)
    ) u_filt (
        .wr_en    (wr_en),
        .addr     (addr),
        .size     (size),
        .wdata    (wdata),
        .old_b    (old_b),
        .bar_mask (bar_mask),
        .rom_mask (rom_mask),
        .lanes    (lanes),
        .touch_cmd(touch_cmd)
    );

    cfghdr_read_mux #(
        .VENDOR_ID  (VENDOR_ID),
        .DEVICE_ID  (DEVICE_ID),
        .REVISION   (REVISION),
        .CLASS_CODE (CLASS_CODE),
        .HEADER_TYPE(HEADER_TYPE),
        .STAT_LO_VAL(STAT_LO_VAL)
    ) u_rd (
        .addr (addr),
        .size (size),
        .cfg  (cfg_q),
        .rdata(rdata)
    );

    // Error events win over a same-cycle clear of the same bit.
    always_comb begin
        stat_set      = err_set & STAT_HI_W1C;
        stat_hi_after = cfg_q[STAT_HI_OFF];
        for (int i = 0; i < LANES; i++)
            if (lanes[i].en && lanes[i].off == STAT_HI_OFF)
                stat_hi_after = lanes[i].val;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            remap_q <= 1'b0;
        end else begin
            for (int i = 0; i < LANES; i++)
                if (lanes[i].en)
                    cfg_q[lanes[i].off] <= lanes[i].val;
            if (|stat_set)
                cfg_q[STAT_HI_OFF] <= stat_hi_after | stat_set;
            remap_q <= touch_cmd;
        end
    end

    assign io_en       = cfg_q[CMD_LO_OFF][0];
    assign mem_en      = cfg_q[CMD_LO_OFF][1];
    assign remap_pulse = remap_q;
endmodule

// File: rtl/cfghdr_regfile_chk.sv
module cfghdr_regfile_chk
    import cfghdr_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h0,
    parameter logic [15:0] DEVICE_ID = 16'h0
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        addr,
    input logic [1:0]        size,
    input logic [DATA_W-1:0] rdata,
    input logic              io_en,
    input logic              mem_en,
    input logic              remap_pulse
);
    logic hits_cmd;
    always_comb begin
        hits_cmd = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            logic [7:0] o;
            o = addr + 8'(i);
            if (3'(i) < lane_count(size) && (o == 8'h04 || o == 8'h05))
                hits_cmd = 1'b1;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!io_en && !mem_en && !remap_pulse)); // R13

    AST_REMAP_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        remap_pulse |-> ($past(wr_en) && $past(hits_cmd))); // R10

    AST_ENABLES_MOVE_WITH_REMAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (!$stable(io_en) || !$stable(mem_en))) |-> remap_pulse); // R11

    AST_BYTE_READ_NARROW: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_BYTE) |-> (rdata[31:8] == 24'h0)); // R2

    AST_ID_FIXED: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_DWORD && addr == 8'h00) |-> (rdata == {DEVICE_ID, VENDOR_ID})); // R1

    AST_CMD_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (size == SZ_WORD && addr == 8'h04) |-> (rdata[15:11] == 5'h0)); // R7
endmodule

bind cfghdr_regfile cfghdr_regfile_chk #(
    .VENDOR_ID(VENDOR_ID),
    .DEVICE_ID(DEVICE_ID)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .addr       (addr),
    .size       (size),
    .rdata      (rdata),
    .io_en      (io_en),
    .mem_en     (mem_en),
    .remap_pulse(remap_pulse)
);

// File: tb/cfghdr_regfile_tb_top.sv
module cfghdr_regfile_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h0;
    logic [1:0]  size = 2'd0;
    logic [31:0] wdata = 32'h0;
    logic [7:0]  err_set = 8'h0;
    logic [31:0] rdata;
    logic        io_en, mem_en, remap_pulse;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cfghdr_regfile dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .size(size),
        .wdata(wdata), .err_set(err_set), .rdata(rdata),
        .io_en(io_en), .mem_en(mem_en), .remap_pulse(remap_pulse)
    );

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [1:0]  size;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 2'd2, 32'h00A51B36, 8'd1},  // R1 ids
        '{1'b1, 8'h00, 2'd2, 32'hFFFFFFFF, 8'd1},
        '{1'b0, 8'h00, 2'd2, 32'h00A51B36, 8'd1},  // R1 ids unchanged
        '{1'b0, 8'h08, 2'd2, 32'h02000002, 8'd1},  // R1 rev/class
        '{1'b1, 8'h0E, 2'd0, 32'h00000080, 8'd1},
        '{1'b0, 8'h0E, 2'd0, 32'h00000000, 8'd1},  // R1 header type
        '{1'b1, 8'h10, 2'd2, 32'hFFFFFFFF, 8'd3},
        '{1'b0, 8'h10, 2'd2, 32'hFFFFF000, 8'd3},  // R3 4 KiB
        '{1'b1, 8'h14, 2'd2, 32'h12345678, 8'd3},
        '{1'b0, 8'h14, 2'd2, 32'h12345660, 8'd3},  // R3 32 B
        '{1'b1, 8'h18, 2'd2, 32'hFFFFFFFF, 8'd4},
        '{1'b0, 8'h18, 2'd2, 32'h00000000, 8'd4},  // R4 unimplemented
        '{1'b1, 8'h11, 2'd0, 32'h000000AA, 8'd5},
        '{1'b0, 8'h10, 2'd2, 32'hFFFFF000, 8'd5},  // R5 byte into BAR
        '{1'b1, 8'h14, 2'd1, 32'h0000BEEF, 8'd5},
        '{1'b0, 8'h14, 2'd2, 32'h12345660, 8'd5},  // R5 word into BAR
        '{1'b1, 8'h30, 2'd2, 32'hABCDEF57, 8'd6},
        '{1'b0, 8'h30, 2'd2, 32'hABCD0001, 8'd6},  // R6 enable kept
        '{1'b1, 8'h30, 2'd2, 32'h0001FFFE, 8'd6},
        '{1'b0, 8'h30, 2'd2, 32'h00010000, 8'd6},  // R6 enable off
        '{1'b1, 8'h32, 2'd0, 32'h00000055, 8'd5},
        '{1'b0, 8'h30, 2'd2, 32'h00010000, 8'd5},  // R5 byte into ROM
        '{1'b1, 8'h38, 2'd2, 32'hFFFFFFFF, 8'd5},
        '{1'b0, 8'h38, 2'd2, 32'h00000000, 8'd5},  // R5 reserved ROM slot
        '{1'b1, 8'h3C, 2'd1, 32'h0000A50B, 8'd12},
        '{1'b0, 8'h3C, 2'd2, 32'h0000A50B, 8'd12}, // R12 plain word
        '{1'b0, 8'h3D, 2'd0, 32'h000000A5, 8'd2}   // R2 byte read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; size = s; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [7:0] a, input logic [1:0] s);
        @(negedge clk);
        addr = a; size = s;
        #1;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        apply_reset();
        // R13 reset state
        do_rd(8'h04, 2'd1);
        check("R13 cmd", rdata, 32'h0);
        check("R13 en", {30'h0, io_en, mem_en}, 32'h0);
        check("R13 remap", {31'h0, remap_pulse}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].is_wr)
                do_wr(VECS[i].addr, VECS[i].size, VECS[i].data);
            else begin
                do_rd(VECS[i].addr, VECS[i].size);
                check($sformatf("R%0d vec%0d", VECS[i].req, i), rdata, VECS[i].data);
            end
        end

        // R2 little-endian and unaligned reads
        do_wr(8'h40, 2'd2, 32'h11223344);
        do_rd(8'h42, 2'd1); check("R2 word hi", rdata, 32'h1122);
        do_rd(8'h41, 2'd1); check("R2 unaligned word", rdata, 32'h2233);
        do_rd(8'h41, 2'd0); check("R2 byte", rdata, 32'h33);

        // R8 status low read-only
        do_wr(8'h06, 2'd1, 32'h0000FFFF);
        do_rd(8'h06, 2'd1); check("R8 status", rdata, 32'h0);

        // R10 / R7 / R11 command register
        do_wr(8'h04, 2'd1, 32'h0000FFFF);
        check("R10 pulse after cmd write", {31'h0, remap_pulse}, 32'h1);
        check("R11 both enables", {30'h0, io_en, mem_en}, 32'h3);
        @(negedge clk);
        check("R10 pulse single", {31'h0, remap_pulse}, 32'h0);
        do_rd(8'h04, 2'd1); check("R7 reserved bits", rdata, 32'h07FF);
        do_wr(8'h05, 2'd0, 32'h000000F8);
        do_rd(8'h05, 2'd0); check("R7 writable bits cleared", rdata, 32'h0);
        do_wr(8'h04, 2'd0, 32'h00000001);
        check("R11 io only", {30'h0, io_en, mem_en}, 32'h2);
        do_wr(8'h04, 2'd0, 32'h00000002);
        check("R11 mem only", {30'h0, io_en, mem_en}, 32'h1);
        do_wr(8'h3C, 2'd0, 32'h00000011);
        check("R10 no pulse elsewhere", {31'h0, remap_pulse}, 32'h0);
        do_wr(8'h02, 2'd2, 32'h0);
        check("R10 dword spanning cmd", {31'h0, remap_pulse}, 32'h1);

        // R9 status high set / write-one-to-clear
        @(negedge clk); err_set = 8'hFF;
        @(negedge clk); err_set = 8'h00;
        do_rd(8'h06, 2'd1); check("R9 set masked", rdata, 32'hF900);
        do_wr(8'h07, 2'd0, 32'h00000009);
        do_rd(8'h07, 2'd0); check("R9 clear by one", rdata, 32'hF0);
        do_wr(8'h07, 2'd0, 32'h00000000);
        do_rd(8'h07, 2'd0); check("R9 zero keeps", rdata, 32'hF0);

        // R13 reset mid-run
        apply_reset();
        do_rd(8'h40, 2'd2); check("R13 plain cleared", rdata, 32'h0);
        do_rd(8'h10, 2'd2); check("R13 bar cleared", rdata, 32'h0);
        check("R13 enables cleared", {30'h0, io_en, mem_en}, 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule